// File: doc/BRIEF.md
# SPI Card Host Port

This block connects a byte-wide host register bus to a memory card that speaks SPI. Software reaches three registers: a transfer register that sends a byte to the card and holds the byte that came back, a control register that selects the card, picks the serial clock rate and chooses how transfers are started, and a status register that shows whether the port is busy and reports the card-detect and write-protect switches.

The serial side runs in SPI mode 0: eight bits per exchange, most significant bit first. MOSI is set up while SCLK is low, MISO is sampled on the rising edge and the shift happens on the falling edge. Two SCLK rates come from the system clock through two half-period divide parameters, and a control bit picks one at run time. A transfer starts on a write of the transfer register or, in read-trigger mode, on a read of it. Read-trigger mode lets software stream data out of a card with one bus read per byte.

The chip-select control bit drives the card's active-low select and an active-low activity LED together.

Top module: `spi_card_host`

## Requirements
- R1: With control bit 6 = 0 and the port idle, a bus write to address 0 starts an exchange that sends the written byte MSB first in SPI mode 0. MOSI changes only while SCLK falls.
- R2: When an exchange ends, the byte received on MISO (MSB first, sampled on SCLK rising) is read back at address 0.
- R3: With control bit 6 = 1, a bus read of address 0 returns the byte received by the previous exchange and starts a new exchange that sends 0xFF. A bus write to address 0 in this mode starts nothing.
- R4: With control bit 6 = 0, a bus read of address 0 starts nothing.
- R5: A trigger that arrives while an exchange is running, including in its last cycle, is ignored: the running byte, its response and its length are unchanged and no second exchange follows.
- R6: Control bit 2 picks the rate. An exchange lasts 16*FAST_HALF clock cycles when the bit is 1 and 16*SLOW_HALF cycles when it is 0.
- R7: Control bit 1 (address 1) drives spi_cs_n and led_n directly, so 0 selects the card and lights the LED. They change only on a control write.
- R8: Status bit 0 (address 2) reads 1 from the cycle after a trigger is accepted until the exchange ends, and 0 otherwise.
- R9: Status bit 3 follows card_absent and status bit 4 follows card_wprot through a two-flip-flop synchronizer, so an input change is visible after two clock edges.
- R10: Control bits 0, 3, 4, 5 and 7 and status bits 1, 2, 5, 6 and 7 always read 0. Control bits 1, 2 and 6 read back as written.
- R11: After reset the control register reads 0x02 (card deselected, slow rate, write trigger) and address 0 reads 0x00. While idle, SCLK is low and MOSI is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 transfer, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, decoded from bus_addr in the same cycle |
| spi_sclk | output | 1 | Serial clock to the card, idle low |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Card select, active low |
| card_absent | input | 1 | Card-detect switch, 1 when no card is present (asynchronous) |
| card_wprot | input | 1 | Write-protect switch, 1 when protected (asynchronous) |
| led_n | output | 1 | Activity LED, active low |

## Verification
A new trigger and the end of a running exchange can fall on the same clock edge. The bench drives a write of the transfer register exactly on the edge that drops busy, and another in the middle of the exchange. It then judges the outcome from the card model: the bits captured on MOSI, the number of SCLK falling edges, and the byte read back at address 0 must all belong to the first exchange alone. In read-trigger mode, the return of the old byte and the start of the next exchange happen in one bus read, and this is checked by the value returned and by the 0xFF that the card model collects.

// File: rtl/spi_card_pkg.sv
// Package: spi_card_pkg
// Holds the register addresses, the bit positions software relies on and the
// control register type used by the SPI card host port.
package spi_card_pkg;

    localparam int XFER_BITS = 8;

    localparam logic [1:0] REG_XFER = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam int CTL_DESEL  = 1;
    localparam int CTL_FAST   = 2;
    localparam int CTL_RDTRIG = 6;

    localparam int STS_BUSY   = 0;
    localparam int STS_NOCARD = 3;
    localparam int STS_WPROT  = 4;

    typedef struct packed {
        logic rd_trig;
        logic fast;
        logic desel;
    } ctrl_t;

endpackage

// File: rtl/spi_card_sync.sv
// Module: spi_card_sync
// A chain of flip-flops that brings slow asynchronous switch inputs into the
// clock domain. It assumes the inputs change much more slowly than clk.
// All stages reset to RST_VAL.
module spi_card_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift each input sample one stage along per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_card_clkgen.sv
// Module: spi_card_clkgen
// Gives a one-cycle tick each time half an SCLK period has passed while run
// is high. The half period is FAST_HALF or SLOW_HALF clock cycles, picked by
// fast. The count restarts whenever run is low, so the first tick comes a full
// half period after an exchange starts.
module spi_card_clkgen #(
    parameter int SLOW_HALF = 200,
    parameter int FAST_HALF = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Choose the terminal count for the selected rate.
    always_comb begin
        limit = fast ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);
    end

    // Count cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt >= limit);

endmodule

// File: rtl/spi_card_shifter.sv
// Module: spi_card_shifter
// The SPI mode 0 engine. A start loads the byte to send and raises busy.
// Every tick toggles SCLK: MISO is captured on the rising half and the shift
// register moves on the falling half, so MOSI only changes as SCLK drops.
// Busy clears on the last falling half, when the received byte is stored.
// It assumes start is only given while busy is low.
module spi_card_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            tick,
    input  logic            miso,
    output logic            busy,
    output logic            sclk,
    output logic            mosi,
    output logic [BITS-1:0] rx_byte
);

    localparam int BCW = $clog2(BITS);

    logic [BITS-1:0] shreg;
    logic [BCW-1:0]  bitcnt;
    logic            miso_q;
    logic            last_bit;

    assign last_bit = (bitcnt == BCW'(BITS - 1));

    // Run the exchange: load, clock out, capture and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            shreg   <= '1;
            bitcnt  <= '0;
            miso_q  <= 1'b0;
            rx_byte <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            sclk   <= 1'b0;
            shreg  <= tx_byte;
            bitcnt <= '0;
        end else if (busy && tick) begin
            if (!sclk) begin
                sclk   <= 1'b1;
                miso_q <= miso;
            end else begin
                sclk   <= 1'b0;
                shreg  <= {shreg[BITS-2:0], miso_q};
                bitcnt <= bitcnt + 1'b1;
                if (last_bit) begin
                    busy    <= 1'b0;
                    rx_byte <= {shreg[BITS-2:0], miso_q};
                end
            end
        end
    end

    // Hold the data line high between exchanges.
    always_comb begin
        mosi = busy ? shreg[BITS-1] : 1'b1;
    end

endmodule

// File: rtl/spi_card_regs.sv
// Module: spi_card_regs
// The register bus side of the port. It holds the control register, decides
// when a bus access starts an exchange and muxes the read data. Read data is
// combinational from bus_addr. It assumes bus_wr and bus_rd are single-cycle
// strobes.
module spi_card_regs
    import spi_card_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    input  logic       xfer_busy,
    input  logic [7:0] rx_byte,
    input  logic       absent_s,
    input  logic       wprot_s,
    output ctrl_t      ctrl,
    output logic       start,
    output logic [7:0] tx_byte,
    output logic [7:0] bus_rdata
);

    logic wr_xfer;
    logic rd_xfer;
    logic wr_ctrl;

    // Decode the accesses that matter.
    always_comb begin
        wr_xfer = bus_wr && (bus_addr == REG_XFER);
        rd_xfer = bus_rd && (bus_addr == REG_XFER);
        wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    end

    // Update the control fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.desel   <= 1'b1;
            ctrl.fast    <= 1'b0;
            ctrl.rd_trig <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl.desel   <= bus_wdata[CTL_DESEL];
            ctrl.fast    <= bus_wdata[CTL_FAST];
            ctrl.rd_trig <= bus_wdata[CTL_RDTRIG];
        end
    end

    // Pick the trigger source and the outgoing byte for the current mode.
    always_comb begin
        if (ctrl.rd_trig) begin
            start   = rd_xfer && !xfer_busy;
            tx_byte = 8'hFF;
        end else begin
            start   = wr_xfer && !xfer_busy;
            tx_byte = bus_wdata;
        end
    end

    // Assemble the read data for the addressed register.
    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            REG_XFER: bus_rdata = rx_byte;
            REG_CTRL: begin
                bus_rdata[CTL_DESEL]  = ctrl.desel;
                bus_rdata[CTL_FAST]   = ctrl.fast;
                bus_rdata[CTL_RDTRIG] = ctrl.rd_trig;
            end
            REG_STAT: begin
                bus_rdata[STS_BUSY]   = xfer_busy;
                bus_rdata[STS_NOCARD] = absent_s;
                bus_rdata[STS_WPROT]  = wprot_s;
            end
            default: bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/spi_card_host.sv
// Module: spi_card_host
// Top level of the SPI card host port. It ties the register block, the SCLK
// tick generator, the shift engine and the switch synchronizer together.
// SLOW_HALF and FAST_HALF are SCLK half periods in clk cycles. The defaults
// give about 250 kHz and 8 MHz from a 100 MHz clock.
module spi_card_host
    import spi_card_pkg::*;
#(
    parameter int SLOW_HALF = 200,
    parameter int FAST_HALF = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n,
    input  logic       card_absent,
    input  logic       card_wprot,
    output logic       led_n
);

    ctrl_t                ctrl;
    logic                 start;
    logic [XFER_BITS-1:0] tx_byte;
    logic [XFER_BITS-1:0] rx_byte;
    logic                 xfer_busy;
    logic                 tick;
    logic [1:0]           sw_sync;

    spi_card_sync #(
        .WIDTH  (2),
        .STAGES (2),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({card_wprot, card_absent}),
        .q    (sw_sync)
    );

    spi_card_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .xfer_busy(xfer_busy),
        .rx_byte  (rx_byte),
        .absent_s (sw_sync[0]),
        .wprot_s  (sw_sync[1]),
        .ctrl     (ctrl),
        .start    (start),
        .tx_byte  (tx_byte),
        .bus_rdata(bus_rdata)
    );

    spi_card_clkgen #(
        .SLOW_HALF(SLOW_HALF),
        .FAST_HALF(FAST_HALF)
    ) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (xfer_busy),
        .fast (ctrl.fast),
        .tick (tick)
    );

    spi_card_shifter #(
        .BITS(XFER_BITS)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_byte(tx_byte),
        .tick   (tick),
        .miso   (spi_miso),
        .busy   (xfer_busy),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .rx_byte(rx_byte)
    );

    // Select line and LED both follow the deselect control bit.
    always_comb begin
        spi_cs_n = ctrl.desel;
        led_n    = ctrl.desel;
    end

endmodule

// File: rtl/spi_card_host_chk.sv
// Module: spi_card_host_chk
// Assertion checker bound into spi_card_host. It watches the ports plus the
// busy flag and the rate bit, and keeps its own counters for the length
// window and the cycles since reset.
module spi_card_host_chk
    import spi_card_pkg::*;
#(
    parameter int SLOW_HALF = 200,
    parameter int FAST_HALF = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_cs_n,
    input logic       card_absent,
    input logic       xfer_busy,
    input logic       rate_fast
);

    int busy_len;
    int since_rst;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !xfer_busy) busy_len <= 0;
        else                      busy_len <= busy_len + 1;
    end

    // Count cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_rst <= 0;
        else if (since_rst < 4) since_rst <= since_rst + 1;
    end

    assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (!spi_sclk && spi_mosi));

    assert_start_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 1 && $rose(xfer_busy)) |-> ($past(bus_wr || bus_rd) && $past(bus_addr) == REG_XFER));

    assert_mosi_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && $past(xfer_busy) && !$stable(spi_mosi)) |-> $fell(spi_sclk));

    assert_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_CTRL) |=> $stable(spi_cs_n));

    assert_ctrl_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTRL) |-> ((bus_rdata & 8'hB9) == 8'h00));

    assert_xfer_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 1 && $fell(xfer_busy)) |->
            (busy_len == (rate_fast ? 16 * FAST_HALF : 16 * SLOW_HALF)));

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3 && bus_addr == REG_STAT) |-> (bus_rdata[STS_NOCARD] == $past(card_absent, 2)));

endmodule

bind spi_card_host spi_card_host_chk #(
    .SLOW_HALF(SLOW_HALF),
    .FAST_HALF(FAST_HALF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n),
    .card_absent(card_absent),
    .xfer_busy  (xfer_busy),
    .rate_fast  (ctrl.fast)
);

// File: tb/test_spi_card_host.sv
// Bench for spi_card_host: small divide ratios, a card model that answers
// with a chosen byte, full byte sweeps and targeted corner cases.
module test_spi_card_host;

    localparam int SLOW = 4;
    localparam int FAST = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_mosi, spi_miso, spi_cs_n, led_n;
    logic       card_absent = 1'b0;
    logic       card_wprot = 1'b0;

    logic [7:0] sl_resp = 8'h00;
    logic [7:0] sl_rx = 8'h00;
    logic [2:0] nfall = 3'd0;
    int         fall_total = 0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spi_card_host #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) i_spi_card_host (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .card_absent(card_absent), .card_wprot(card_wprot),
        .led_n(led_n)
    );

    // Card model: answers MSB first, collects MOSI on rising SCLK.
    assign spi_miso = sl_resp[3'd7 - nfall];
    always @(posedge spi_sclk) sl_rx <= {sl_rx[6:0], spi_mosi};
    always @(negedge spi_sclk) begin
        nfall      <= nfall + 3'd1;
        fall_total <= fall_total + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(output int n);
        logic [7:0] s;
        n = 0;
        forever begin
            peek(2'd2, s);
            if (!s[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic xfer(logic [7:0] tx, logic [7:0] resp, int half);
        logic [7:0] s, d;
        int n;
        sl_resp = resp;
        bus_write(2'd0, tx);
        peek(2'd2, s);
        chk("R8 busy after trigger", int'(s[0]), 1);
        wait_done(n);
        chk("R6 exchange length", n, 16 * half);
        chk("R1 byte seen by card", int'(sl_rx), int'(tx));
        bus_read(2'd0, d);
        chk("R2 received byte", int'(d), int'(resp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual 0 expected 1");
        summary();
    end

    initial begin
        logic [7:0] d, s;
        int n, f0;
        logic [7:0] first_tx, first_rsp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 reset state
        chk("R11 sclk idle low", int'(spi_sclk), 0);
        chk("R11 mosi idle high", int'(spi_mosi), 1);
        chk("R11 cs_n after reset", int'(spi_cs_n), 1);
        peek(2'd1, d); chk("R11 control reset", int'(d), 8'h02);
        peek(2'd0, d); chk("R11 data reset", int'(d), 8'h00);
        peek(2'd2, d); chk("R8 status idle", int'(d), 8'h00);

        // R10 / R7 control readback and select lines
        bus_write(2'd1, 8'hFF);
        peek(2'd1, d); chk("R10 control readback ones", int'(d), 8'h46);
        chk("R7 cs_n deselected", int'(spi_cs_n), 1);
        chk("R7 led off", int'(led_n), 1);
        bus_write(2'd1, 8'h00);
        peek(2'd1, d); chk("R10 control readback zero", int'(d), 8'h00);
        chk("R7 cs_n selected", int'(spi_cs_n), 0);
        chk("R7 led on", int'(led_n), 0);

        // R6 slow rate exchanges, R1/R2
        for (int v = 0; v < 8; v++) begin
            xfer(8'(v * 37 + 3), 8'(v * 11) ^ 8'hC3, SLOW);
        end

        // R1/R2/R6 full sweep at fast rate
        bus_write(2'd1, 8'h04);
        for (int v = 0; v < 256; v++) begin
            xfer(8'(v), 8'(v * 29 + 7) ^ 8'h5A, FAST);
        end
        chk("R11 mosi high after exchange", int'(spi_mosi), 1);

        // R4 read in write-trigger mode starts nothing
        f0 = fall_total;
        bus_read(2'd0, d);
        peek(2'd2, s);
        chk("R4 read does not start", int'(s[0]), 0);
        repeat (20) @(negedge clk);
        chk("R4 no SCLK activity", fall_total - f0, 0);

        // R5 triggers mid-exchange and in its last cycle
        bus_write(2'd1, 8'h00);
        first_tx = 8'h96; first_rsp = 8'h3D;
        sl_resp = first_rsp;
        f0 = fall_total;
        bus_write(2'd0, first_tx);
        repeat (5) @(negedge clk);
        bus_write(2'd0, 8'h11);
        repeat (16 * SLOW - 7) @(negedge clk);
        bus_write(2'd0, 8'h22);
        peek(2'd2, s);
        chk("R5 idle after end-cycle trigger", int'(s[0]), 0);
        repeat (4 * SLOW) @(negedge clk);
        peek(2'd2, s);
        chk("R5 no second exchange", int'(s[0]), 0);
        chk("R5 SCLK count", fall_total - f0, 8);
        chk("R5 card byte unchanged", int'(sl_rx), int'(first_tx));
        peek(2'd0, d);
        chk("R5 response unchanged", int'(d), int'(first_rsp));

        // R3 read-trigger mode
        bus_write(2'd1, 8'h44);
        sl_resp = 8'hA7;
        bus_read(2'd0, d);
        chk("R3 read returns previous byte", int'(d), int'(first_rsp));
        peek(2'd2, s);
        chk("R3 read starts exchange", int'(s[0]), 1);
        f0 = fall_total;
        bus_read(2'd0, d);
        chk("R5 read while busy returns old byte", int'(d), int'(first_rsp));
        wait_done(n);
        chk("R3 card sees 0xFF", int'(sl_rx), 8'hFF);
        chk("R5 read while busy ignored", fall_total - f0, 8);
        for (int v = 0; v < 16; v++) begin
            logic [7:0] prev;
            prev = (v == 0) ? 8'hA7 : 8'(((v - 1) * 53 + 1) ^ 8'h0F);
            sl_resp = 8'((v * 53 + 1) ^ 8'h0F);
            bus_read(2'd0, d);
            chk("R3 streamed byte", int'(d), int'(prev));
            wait_done(n);
            chk("R3 length fast", n, 16 * FAST);
        end
        f0 = fall_total;
        bus_write(2'd0, 8'h00);
        peek(2'd2, s);
        chk("R3 write ignored in read mode", int'(s[0]), 0);
        repeat (10) @(negedge clk);
        chk("R3 no SCLK from write", fall_total - f0, 0);

        // R9 switch synchronizer sweep
        for (int v = 0; v < 4; v++) begin
            logic [1:0] old;
            peek(2'd2, s);
            old = {s[4], s[3]};
            card_absent = v[0];
            card_wprot  = v[1];
            @(negedge clk);
            peek(2'd2, s);
            chk("R9 one edge keeps old", int'({s[4], s[3]}), int'(old));
            @(negedge clk);
            peek(2'd2, s);
            chk("R9 two edges show new", int'({s[4], s[3]}), v);
            chk("R10 status reserved", int'(s & 8'hE6), 0);
        end

        summary();
    end

endmodule